// File: doc/BRIEF.md
# Keyed Unstoppable Watchdog Timer

This block guards a processor against running away. A counter, clocked by its own free-running low-speed oscillator, measures how long it has been since software last serviced it. If software lets the count reach the programmed limit, the block drives a system reset pulse. The pulse lasts a fixed number of watchdog-clock cycles, and the counter then starts again from zero.

Software services the timer by writing one particular key byte (0x55) to one particular bus address (0x20). Any other value, any other address, or a bus cycle without the write strobe leaves the count alone. The write happens in the system clock domain. It crosses into the watchdog domain as a toggle, with an acknowledge toggle that comes back, so no service request is lost or doubled. Every system reset clears and arms the timer. No input can turn it off, and it keeps counting while the system clock is stopped.

The timeout is a parameter counted in watchdog-clock cycles. The default is sized for roughly half a second on a 32 kHz oscillator.

Top module: `wdog_keyed`

## Requirements
- R1: While `sys_rst_n` is low, `wd_bite` is low and the count is cleared. After `sys_rst_n` rises, the first pulse comes no earlier than TIMEOUT_CYCLES+1 and no later than TIMEOUT_CYCLES+4 watchdog-clock cycles later, the extra cycles being the reset synchronizer. `wd_bite` falls as soon as `sys_rst_n` falls, even in the middle of a pulse.
- R2: With no valid service, `wd_bite` stays low for exactly TIMEOUT_CYCLES watchdog-clock cycles counted from the start of the count, then rises.
- R3: Each pulse on `wd_bite` is high for exactly PULSE_CYCLES watchdog-clock cycles.
- R4: After a pulse the count restarts from zero, so an unserviced timer produces a steady train: TIMEOUT_CYCLES low, then PULSE_CYCLES high.
- R5: A write with `bus_wr_en`=1, `bus_addr`=0x20 and `bus_wdata`=0x55 restarts the count. The restart takes effect in the watchdog domain within 2 system cycles plus 4 watchdog cycles of the write.
- R6: A write to 0x20 of any data value other than 0x55 has no effect on the count.
- R7: The key value 0x55 on the bus has no effect if the address is not 0x20 or if `bus_wr_en` is low.
- R8: A key write that reaches the watchdog domain while `wd_bite` is high changes neither the pulse length nor the following full TIMEOUT_CYCLES low period.
- R9: The count and the reset pulses continue unchanged while `sys_clk` is stopped.
- R10: Key writes issued faster than the crossing can carry them are merged, never dropped. While software keeps writing the key, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (bus) clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; clears both domains |
| bus_wr_en | input | 1 | Bus write strobe, one system cycle per write |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | DATA_W | Bus write data |
| wd_clk | input | 1 | Free-running watchdog oscillator clock |
| wd_bite | output | 1 | Reset request pulse, active high, in the watchdog clock domain |

## Verification
A wrong count or a lost service request cannot be seen until a pulse edge. A counter that is off by one shows as a low period one cycle too long or too short, which appears only when the next pulse rises, TIMEOUT_CYCLES later. A dropped or mis-decoded key write shows only as a pulse that arrives about twenty cycles earlier than a restarted count allows. So every window is measured exactly, edge to edge, in watchdog cycles. Faults in the crossing first show as missing restarts under dense write streams, or as restarts while the clock is gated off. The bench therefore drives both of those conditions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    WD_COUNT = 1'b0,
    WD_FIRE  = 1'b1
  } wd_state_e;

  // True when a bus cycle is a write of the key value to the service address.
  function automatic logic key_match(
    input logic        en,
    input logic [31:0] addr,
    input logic [31:0] want_addr,
    input logic [31:0] data,
    input logic [31:0] key
  );
    return en && (addr == want_addr) && (data == key);
  endfunction

  // Width that holds values 0 .. n-1, never less than one bit.
  function automatic int unsigned span_width(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

  // True when a counter of 0 .. n-1 sits on its last value.
  function automatic logic at_last(input logic [31:0] cnt, input int unsigned n);
    return cnt == 32'(n - 1);
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/wdog_kick_tx.sv
module wdog_kick_tx #(
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          DATA_W    = 8,
  parameter logic [ADDR_W-1:0]    KICK_ADDR = '0,
  parameter logic [DATA_W-1:0]    KICK_KEY  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic              key_seen
);
  import wdog_pkg::*;

  logic ack_s1, ack_s2;
  logic pending;
  logic busy;
  logic launch;

  assign key_seen = key_match(wr_en, 32'(addr), 32'(KICK_ADDR), 32'(wdata), 32'(KICK_KEY));
  assign busy     = req_tgl ^ ack_s2;
  assign launch   = (pending | key_seen) & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
      pending <= 1'b0;
      req_tgl <= 1'b0;
    end else begin
      ack_s1  <= ack_tgl;
      ack_s2  <= ack_s1;
      pending <= (pending | key_seen) & ~launch;
      req_tgl <= req_tgl ^ launch;
    end
  end

  // R10: a new request leaves only once the previous one was acknowledged
  a_r10_launch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_tgl) |-> ($past(req_tgl) == $past(ack_s2)));

  // R10: a key write is either sent at once or held pending, never dropped
  a_r10_key_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    key_seen |=> (pending || !$stable(req_tgl)));
endmodule

// File: rtl/wdog_kick_rx.sv
module wdog_kick_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic kick,
  output logic ack_tgl
);
  logic req_s1, req_s2, req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1   <= 1'b0;
      req_s2   <= 1'b0;
      req_seen <= 1'b0;
    end else begin
      req_s1   <= req_tgl;
      req_s2   <= req_s1;
      req_seen <= req_s2;
    end
  end

  assign kick    = req_s2 ^ req_seen;
  assign ack_tgl = req_seen;

  // R5: one toggle yields exactly one single-cycle restart request
  a_r5_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 16384,
  parameter int unsigned PULSE_CYCLES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic bite
);
  import wdog_pkg::*;

  localparam int unsigned CNT_W = span_width(TIMEOUT_CYCLES);
  localparam int unsigned PLS_W = span_width(PULSE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(PULSE_CYCLES - 1);

  wd_state_e        state;
  logic [CNT_W-1:0] count;
  logic [PLS_W-1:0] pcnt;

  // Named internal events
  logic counting;
  logic firing;
  logic restart;
  logic expire;
  logic pulse_done;

  assign counting   = (state == WD_COUNT);
  assign firing     = (state == WD_FIRE);
  assign restart    = counting && kick;
  assign expire     = counting && !kick && at_last(32'(count), TIMEOUT_CYCLES);
  assign pulse_done = firing && at_last(32'(pcnt), PULSE_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WD_COUNT;
      count <= '0;
      pcnt  <= '0;
    end else begin
      case (state)
        WD_COUNT: begin
          if (restart) begin
            count <= '0;
          end else if (expire) begin
            state <= WD_FIRE;
            count <= '0;
            pcnt  <= '0;
          end else begin
            count <= count + 1'b1;
          end
        end
        WD_FIRE: begin
          if (pulse_done) begin
            state <= WD_COUNT;
            count <= '0;
            pcnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: state <= WD_COUNT;
      endcase
    end
  end

  assign bite = firing;

  // R2: the count never passes its last value
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_LAST);

  // R2: a pulse starts only after a full window
  a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bite) |-> ($past(count) == CNT_LAST));

  // R3: a pulse ends only after its full length
  a_r3_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bite) |-> ($past(pcnt) == PLS_LAST));

  // R4: the count starts from zero after every pulse
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bite) |-> (count == '0));

  // R5: a restart request clears the count and keeps the output low
  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0 && !bite));

  // R8: a request during a pulse does not cut it short
  a_r8_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (firing && !pulse_done) |=> bite);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int unsigned       ADDR_W         = 8,
  parameter int unsigned       DATA_W         = 8,
  parameter logic [ADDR_W-1:0] KICK_ADDR      = 8'h20,
  parameter logic [DATA_W-1:0] KICK_KEY       = 8'h55,
  parameter int unsigned       TIMEOUT_CYCLES = 16384,
  parameter int unsigned       PULSE_CYCLES   = 8
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wd_clk,
  output logic              wd_bite
);
  logic wd_rst_n;
  logic req_tgl;
  logic ack_tgl;
  logic key_seen;
  logic kick;

  wdog_rst_sync u_rst_sync (
    .clk    (wd_clk),
    .arst_n (sys_rst_n),
    .srst_n (wd_rst_n)
  );

  wdog_kick_tx #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KICK_ADDR (KICK_ADDR),
    .KICK_KEY  (KICK_KEY)
  ) u_tx (
    .clk      (sys_clk),
    .rst_n    (sys_rst_n),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .ack_tgl  (ack_tgl),
    .req_tgl  (req_tgl),
    .key_seen (key_seen)
  );

  wdog_kick_rx u_rx (
    .clk     (wd_clk),
    .rst_n   (wd_rst_n),
    .req_tgl (req_tgl),
    .kick    (kick),
    .ack_tgl (ack_tgl)
  );

  wdog_timer #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .PULSE_CYCLES   (PULSE_CYCLES)
  ) u_timer (
    .clk   (wd_clk),
    .rst_n (wd_rst_n),
    .kick  (kick),
    .bite  (wd_bite)
  );

  // R1: the reset request is quiet while the watchdog domain is in reset
  a_r1_quiet_in_reset: assert property (@(posedge wd_clk) disable iff (sys_rst_n)
    !wd_bite);
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  localparam int TOUT  = 40;
  localparam int PULSE = 6;
  localparam int LEAD  = 20;

  logic sys_raw = 1'b0;
  logic sys_run = 1'b1;
  logic sys_clk;
  logic wd_clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic bus_wr_en = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic wd_bite;

  int checks = 0;
  int fails  = 0;
  int low_cnt = 0, high_cnt = 0, last_low = 0, last_high = 0, rises = 0;

  always #5 sys_raw = ~sys_raw;
  always #23 wd_clk = ~wd_clk;
  assign sys_clk = sys_raw & sys_run;

  wdog_keyed #(
    .ADDR_W(8), .DATA_W(8), .KICK_ADDR(8'h20), .KICK_KEY(8'h55),
    .TIMEOUT_CYCLES(TOUT), .PULSE_CYCLES(PULSE)
  ) uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wd_clk(wd_clk), .wd_bite(wd_bite)
  );

  // Phase-length monitor, in watchdog cycles
  always @(negedge wd_clk) begin
    if (!sys_rst_n) begin
      low_cnt = 0; high_cnt = 0;
    end else if (!wd_bite) begin
      if (high_cnt != 0) last_high = high_cnt;
      high_cnt = 0;
      low_cnt++;
    end else begin
      if (low_cnt != 0) last_low = low_cnt;
      if (high_cnt == 0) rises++;
      low_cnt = 0;
      high_cnt++;
    end
  end

  // addr, data, wr_en, restart expected
  localparam logic [17:0] VECS [0:7] = '{
    {8'h20, 8'h55, 1'b1, 1'b1},
    {8'h20, 8'h54, 1'b1, 1'b0},
    {8'h20, 8'hAA, 1'b1, 1'b0},
    {8'h21, 8'h55, 1'b1, 1'b0},
    {8'hA0, 8'h55, 1'b1, 1'b0},
    {8'h20, 8'h55, 1'b0, 1'b0},
    {8'h20, 8'hD5, 1'b1, 1'b0},
    {8'h20, 8'h55, 1'b1, 1'b1}
  };

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic en);
    @(negedge sys_clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = en;
    @(negedge sys_clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic wait_rise_sample;
    @(posedge wd_bite);
    @(negedge wd_clk);
    #1;
  endtask

  task automatic wait_fall_sample;
    @(negedge wd_bite);
    @(negedge wd_clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL all: watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: quiet in reset, then first window after release
    #100;
    check_range("R1", int'(wd_bite), 0, 0);
    sys_rst_n = 1'b1;
    wait_rise_sample();
    check_range("R1", last_low, TOUT + 1, TOUT + 4);
    wait_fall_sample();
    check_range("R3", last_high, PULSE, PULSE);
    wait_rise_sample();
    check_range("R2", last_low, TOUT, TOUT);
    wait_fall_sample();
    check_range("R3", last_high, PULSE, PULSE);
    wait_rise_sample();
    check_range("R4", last_low, TOUT, TOUT);

    // R5 / R6 / R7: table of bus cycles, one per window
    for (int i = 0; i < 8; i++) begin
      logic [17:0] v;
      v = VECS[i];
      @(negedge wd_bite);
      repeat (LEAD) @(negedge wd_clk);
      bus_write(v[17:10], v[9:2], v[1]);
      wait_rise_sample();
      if (v[0]) check_range("R5", last_low, TOUT + LEAD + 1, TOUT + LEAD + 6);
      else if (v[17:10] == 8'h20 && v[1]) check_range("R6", last_low, TOUT, TOUT);
      else check_range("R7", last_low, TOUT, TOUT);
    end

    // R8: key write landing during the pulse
    wait_rise_sample();
    bus_write(8'h20, 8'h55, 1'b1);
    wait_fall_sample();
    check_range("R8", last_high, PULSE, PULSE);
    wait_rise_sample();
    check_range("R8", last_low, TOUT, TOUT);

    // R9: system clock stopped
    sys_run = 1'b0;
    wait_fall_sample();
    check_range("R9", last_high, PULSE, PULSE);
    wait_rise_sample();
    check_range("R9", last_low, TOUT, TOUT);
    wait_fall_sample();
    check_range("R9", last_high, PULSE, PULSE);
    sys_run = 1'b1;

    // R10: dense key stream holds off every pulse
    begin
      int r0;
      r0 = rises;
      for (int k = 0; k < 4 * TOUT * 46 / 30; k++) begin
        bus_write(8'h20, 8'h55, 1'b1);
        @(negedge sys_clk);
      end
      check_range("R10", rises - r0, 0, 0);
      wait_rise_sample();
      check_range("R10", last_low, TOUT + 1, 8 * TOUT);
    end

    // R1: reset during a pulse clears it at once, then a full window
    @(posedge wd_bite);
    #10;
    sys_rst_n = 1'b0;
    #1;
    check_range("R1", int'(wd_bite), 0, 0);
    #200;
    sys_rst_n = 1'b1;
    wait_rise_sample();
    check_range("R1", last_low, TOUT + 1, TOUT + 4);

    finish_run();
  end
endmodule